// File: doc/BRIEF.md
# Integer Rename Stage with Copy Elimination

This block is the rename stage of a small out-of-order integer core. Every cycle it takes a bundle of up to `LANES` decoded operations. Each operation carries two source register indices, one destination index and a kind. For every operation it returns the physical register numbers of its sources and of its destination, plus a flag that is set when the operation finished at rename and needs no execution slot. The map table starts with every architectural register pointing at physical register 0. That register is a permanent zero register and is never handed back.

A register-to-register copy is normally completed at rename. The destination's map entry is simply pointed at the source's physical register. A physical register that two or more architectural registers share takes one entry of a small pool of sharing slots. Each slot holds a count of the names that use the register. When overwrites bring that count back down to one, the slot is freed. A copy that cannot be completed at rename becomes an ordinary operation: it takes a fresh register and issues a copy. The following limits apply:
- The number of copies completed per cycle is capped.
- The cap tightens after a cycle that completed the full number.
- A zeroing idiom is always completed at rename, onto the zero register, and uses no slot.

The free list sits outside the block. It offers up to `LANES` candidate registers and a count, and the block reports how many it took. When a destination is overwritten, its previous register is reported on a release port, provided nothing else still names it.

Top module: `rn_rename`

## Requirements
- R1: After reset, every architectural register maps to physical register 0, all sharing slots are empty, the previous-cycle copy count is 0 and `out_valid` is 0.
- R2: A kind-0 (plain) operation with `in_wr`=1 takes the next unused free-list candidate in lane order (`fl_preg[0]` first) as its destination. `fl_pop` equals the number of candidates taken.
- R3: A kind-1 (copy) operation completed at rename reports `out_elim`=1 and `out_pdst` equal to its `out_psrc_a`. It takes no free-list entry.
- R4: At most 2 copies are completed at rename in a cycle. If the previous cycle completed 2, at most 1 is completed. A cycle with no accepted bundle counts as 0.
- R5: A physical register other than 0 that is named by two or more architectural registers holds exactly one of the 4 sharing slots. A copy whose source would need a new slot while none is free falls back: `out_elim`=0, with a fresh register from the free list.
- R6: Overwriting names of a shared register frees its slot once only one name remains, so a later copy can use the slot. A register that is still named is never released.
- R7: A kind-2 (zeroing) operation maps its destination to register 0 with `out_elim`=1 and reports sources 0. It uses no slot and no free-list entry. A copy whose source maps to register 0 is completed without a slot.
- R8: The second lane sees the map updates of the first lane in the same bundle, including a register shared through a copy completed at rename.
- R9: If the bundle needs more fresh registers than `fl_count`, `in_ready` is 0. Then nothing in the bundle is renamed, and `fl_pop` is 0 whenever no bundle is accepted.
- R10: Results of an accepted bundle appear on the output registers in the next cycle with `out_valid`=1. `out_valid` is 0 after a cycle with no accepted bundle.
- R11: When a write replaces a mapping to a register other than 0 that no other name uses, `out_rel_vld` is 1 with that register on `out_rel_preg`. Otherwise `out_rel_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A bundle is offered |
| in_ready | output | 1 | The offered bundle can be accepted this cycle |
| in_op_vld | input | LANES | Per-lane operation present |
| in_kind | input | LANES×2 | 0 plain, 1 copy, 2 zeroing |
| in_wr | input | LANES | Plain operation writes a destination |
| in_src_a | input | LANES×4 | First source index (copy source) |
| in_src_b | input | LANES×4 | Second source index |
| in_dst | input | LANES×4 | Destination index |
| fl_count | input | 2 | Number of valid free-list candidates |
| fl_preg | input | LANES×6 | Free-list candidates, lane order |
| fl_pop | output | 2 | Candidates consumed this cycle |
| out_valid | output | 1 | Renamed bundle valid |
| out_op_vld | output | LANES | Per-lane operation present |
| out_psrc_a | output | LANES×6 | Physical first source |
| out_psrc_b | output | LANES×6 | Physical second source |
| out_pdst | output | LANES×6 | Physical destination |
| out_elim | output | LANES | Completed at rename, no execution needed |
| out_rel_vld | output | LANES | Previous destination register released |
| out_rel_preg | output | LANES×6 | Released physical register |

## Verification
On every cycle, the assertions check these properties:
- A lane completed at rename has a destination equal to its first source.
- Register 0 never appears on the release port.
- A stall happens only when the free list offers fewer than a full bundle of candidates.
- No candidates are popped without an accepted bundle.
- A cycle that completed two copies is never followed by one that completes more than one.

Other behaviours depend on history that spans many cycles, and only the bench's reference model shows them: whether a slot was really available, when sharing ends and a slot is freed, which register is released, and how lane 1 sees lane 0's update. The model tracks one name count per physical register and compares every output each cycle, across directed sequences and a long randomised run.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {
    K_PLAIN = 2'd0,
    K_MOVE  = 2'd1,
    K_ZERO  = 2'd2
  } op_kind_e;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_ARCH = 16,
  parameter int PW       = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [NUM_ARCH-1:0][PW-1:0]   map_d,
  output logic [NUM_ARCH-1:0][PW-1:0]   map_q
);
  // All names start on the zero register.
  for (genvar a = 0; a < NUM_ARCH; a++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)     map_q[a] <= '0;
      else if (we) map_q[a] <= map_d[a];
    end
  end
endmodule

// File: rtl/rn_slot_pool.sv
module rn_slot_pool #(
  parameter int NUM_SLOTS = 4,
  parameter int PW        = 6,
  parameter int CNT_W     = 5
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [NUM_SLOTS-1:0]            vld_d,
  input  logic [NUM_SLOTS-1:0][PW-1:0]    preg_d,
  input  logic [NUM_SLOTS-1:0][CNT_W-1:0] cnt_d,
  output logic [NUM_SLOTS-1:0]            vld_q,
  output logic [NUM_SLOTS-1:0][PW-1:0]    preg_q,
  output logic [NUM_SLOTS-1:0][CNT_W-1:0] cnt_q
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[s]  <= 1'b0;
        preg_q[s] <= '0;
        cnt_q[s]  <= '0;
      end else if (we) begin
        vld_q[s]  <= vld_d[s];
        preg_q[s] <= preg_d[s];
        cnt_q[s]  <= cnt_d[s];
      end
    end
  end
endmodule

// File: rtl/rn_elim_cap.sv
module rn_elim_cap #(
  parameter int CW            = 2,
  parameter int CAP_FULL      = 2,
  parameter int CAP_THROTTLED = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [CW-1:0] n_elim,
  output logic [CW-1:0] cap
);
  logic [CW-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= fire ? n_elim : '0;
  end

  assign cap = (prev_q >= CW'(CAP_FULL)) ? CW'(CAP_THROTTLED) : CW'(CAP_FULL);
endmodule

// File: rtl/rn_rename.sv
module rn_rename
  import rn_pkg::*;
#(
  parameter int NUM_ARCH      = 16,
  parameter int NUM_PHYS      = 64,
  parameter int NUM_SLOTS     = 4,
  parameter int LANES         = 2,
  parameter int CAP_FULL      = 2,
  parameter int CAP_THROTTLED = 1,
  localparam int AW    = $clog2(NUM_ARCH),
  localparam int PW    = $clog2(NUM_PHYS),
  localparam int CW    = $clog2(LANES + 1),
  localparam int CNT_W = $clog2(NUM_ARCH + 1),
  localparam int SIDX  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [LANES-1:0]           in_op_vld,
  input  logic [LANES-1:0][1:0]      in_kind,
  input  logic [LANES-1:0]           in_wr,
  input  logic [LANES-1:0][AW-1:0]   in_src_a,
  input  logic [LANES-1:0][AW-1:0]   in_src_b,
  input  logic [LANES-1:0][AW-1:0]   in_dst,
  input  logic [CW-1:0]              fl_count,
  input  logic [LANES-1:0][PW-1:0]   fl_preg,
  output logic [CW-1:0]              fl_pop,
  output logic                       out_valid,
  output logic [LANES-1:0]           out_op_vld,
  output logic [LANES-1:0][PW-1:0]   out_psrc_a,
  output logic [LANES-1:0][PW-1:0]   out_psrc_b,
  output logic [LANES-1:0][PW-1:0]   out_pdst,
  output logic [LANES-1:0]           out_elim,
  output logic [LANES-1:0]           out_rel_vld,
  output logic [LANES-1:0][PW-1:0]   out_rel_preg
);
  logic [NUM_ARCH-1:0][PW-1:0]    map_q, map_n;
  logic [NUM_SLOTS-1:0]           sv_q, sv_n;
  logic [NUM_SLOTS-1:0][PW-1:0]   sp_q, sp_n;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] sc_q, sc_n;
  logic [LANES-1:0][PW-1:0]       l_pa, l_pb, l_pd, l_rp;
  logic [LANES-1:0]               l_el, l_rv;
  logic [CW-1:0]                  n_alloc, n_mv, cap;
  logic                           fire;

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .PW(PW)) u_map (
    .clk(clk), .rst(rst), .we(fire), .map_d(map_n), .map_q(map_q)
  );

  rn_slot_pool #(.NUM_SLOTS(NUM_SLOTS), .PW(PW), .CNT_W(CNT_W)) u_slots (
    .clk(clk), .rst(rst), .we(fire),
    .vld_d(sv_n), .preg_d(sp_n), .cnt_d(sc_n),
    .vld_q(sv_q), .preg_q(sp_q), .cnt_q(sc_q)
  );

  rn_elim_cap #(.CW(CW), .CAP_FULL(CAP_FULL), .CAP_THROTTLED(CAP_THROTTLED)) u_cap (
    .clk(clk), .rst(rst), .fire(fire), .n_elim(n_mv), .cap(cap)
  );

  // Lanes are evaluated in order on a working copy of the map and the
  // slots, so lane 1 sees everything lane 0 changed.
  always_comb begin : rename_eval
    logic            hit_ok, fr_ok, oh_ok, wrt;
    logic [SIDX-1:0] hit_ix, fr_ix, oh_ix;
    logic [PW-1:0]   src_p, old_p;
    map_n   = map_q;
    sv_n    = sv_q;
    sp_n    = sp_q;
    sc_n    = sc_q;
    n_alloc = '0;
    n_mv    = '0;
    l_pa    = '0;
    l_pb    = '0;
    l_pd    = '0;
    l_rp    = '0;
    l_el    = '0;
    l_rv    = '0;
    for (int i = 0; i < LANES; i++) begin
      hit_ok = 1'b0; fr_ok = 1'b0; oh_ok = 1'b0; wrt = 1'b0;
      hit_ix = '0;   fr_ix = '0;   oh_ix = '0;
      src_p  = map_n[in_src_a[i]];
      old_p  = map_n[in_dst[i]];
      if (in_op_vld[i]) begin
        l_pa[i] = src_p;
        l_pb[i] = map_n[in_src_b[i]];
        for (int s = 0; s < NUM_SLOTS; s++) begin
          if (sv_n[s] && sp_n[s] == src_p) begin
            hit_ok = 1'b1; hit_ix = SIDX'(s);
          end
          if (!sv_n[s] && !fr_ok) begin
            fr_ok = 1'b1; fr_ix = SIDX'(s);
          end
        end
        case (op_kind_e'(in_kind[i]))
          K_MOVE: begin
            wrt = 1'b1;
            if (n_mv < cap && (src_p == '0 || hit_ok || fr_ok)) begin
              l_el[i] = 1'b1;
              n_mv    = n_mv + CW'(1);
              l_pd[i] = src_p;
              if (src_p != '0) begin
                if (hit_ok) begin
                  sc_n[hit_ix] = sc_n[hit_ix] + CNT_W'(1);
                end else begin
                  sv_n[fr_ix] = 1'b1;
                  sp_n[fr_ix] = src_p;
                  sc_n[fr_ix] = CNT_W'(2);
                end
              end
            end else begin
              l_pd[i] = fl_preg[n_alloc];
              n_alloc = n_alloc + CW'(1);
            end
          end
          K_ZERO: begin
            wrt     = 1'b1;
            l_el[i] = 1'b1;
            l_pa[i] = '0;
            l_pb[i] = '0;
            l_pd[i] = '0;
          end
          default: begin
            if (in_wr[i]) begin
              wrt     = 1'b1;
              l_pd[i] = fl_preg[n_alloc];
              n_alloc = n_alloc + CW'(1);
            end
          end
        endcase
        if (wrt) begin
          old_p = map_n[in_dst[i]];
          for (int s = 0; s < NUM_SLOTS; s++) begin
            if (sv_n[s] && sp_n[s] == old_p) begin
              oh_ok = 1'b1; oh_ix = SIDX'(s);
            end
          end
          if (old_p != '0) begin
            if (oh_ok) begin
              sc_n[oh_ix] = sc_n[oh_ix] - CNT_W'(1);
              if (sc_n[oh_ix] == CNT_W'(1)) sv_n[oh_ix] = 1'b0;
            end else begin
              l_rv[i] = 1'b1;
              l_rp[i] = old_p;
            end
          end
          map_n[in_dst[i]] = l_pd[i];
        end
      end
    end
  end

  assign in_ready = (n_alloc <= fl_count);
  assign fire     = in_valid && in_ready;
  assign fl_pop   = fire ? n_alloc : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_op_vld   <= '0;
      out_psrc_a   <= '0;
      out_psrc_b   <= '0;
      out_pdst     <= '0;
      out_elim     <= '0;
      out_rel_vld  <= '0;
      out_rel_preg <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_op_vld   <= in_op_vld;
        out_psrc_a   <= l_pa;
        out_psrc_b   <= l_pb;
        out_pdst     <= l_pd;
        out_elim     <= l_el;
        out_rel_vld  <= l_rv;
        out_rel_preg <= l_rp;
      end
    end
  end
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
  parameter int LANES         = 2,
  parameter int PW            = 6,
  parameter int CW            = 2,
  parameter int CAP_FULL      = 2,
  parameter int CAP_THROTTLED = 1
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [LANES-1:0]         in_op_vld,
  input logic [LANES-1:0][1:0]    in_kind,
  input logic [CW-1:0]            fl_count,
  input logic [CW-1:0]            fl_pop,
  input logic                     out_valid,
  input logic [LANES-1:0]         out_op_vld,
  input logic [LANES-1:0][PW-1:0] out_psrc_a,
  input logic [LANES-1:0][PW-1:0] out_pdst,
  input logic [LANES-1:0]         out_elim,
  input logic [LANES-1:0]         out_rel_vld,
  input logic [LANES-1:0][PW-1:0] out_rel_preg
);
  logic [LANES-1:0][1:0] kind_q;
  logic [LANES-1:0]      mv_vec;

  always_ff @(posedge clk) begin
    if (rst)                        kind_q <= '0;
    else if (in_valid && in_ready)  kind_q <= in_kind;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mv_vec[l] = out_valid && out_op_vld[l] && out_elim[l] && (kind_q[l] == 2'd1);

    // R3: a lane finished at rename writes the register it read
    p_elim_alias_r3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_op_vld[l] && out_elim[l]) |-> (out_pdst[l] == out_psrc_a[l]));

    // R7: the zero register is never handed back
    p_zero_kept_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_rel_vld[l]) |-> (out_rel_preg[l] != '0));
  end

  // R9: a stall only when fewer than a full bundle of candidates is offered
  p_stall_cause_r9: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (int'(fl_count) < LANES));

  // R9: no pop without an accepted bundle
  p_no_pop_r9: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |-> (fl_pop == '0));

  // R2: never take more candidates than offered
  p_pop_bound_r2: assert property (@(posedge clk) disable iff (rst)
    fl_pop <= fl_count);

  // R4: a full-cap cycle is followed by a throttled one
  p_cap_r4: assert property (@(posedge clk) disable iff (rst)
    ($countones(mv_vec) >= CAP_FULL) |=> ($countones(mv_vec) <= CAP_THROTTLED));
endmodule

bind rn_rename rn_rename_chk #(
  .LANES(LANES), .PW(PW), .CW(CW),
  .CAP_FULL(CAP_FULL), .CAP_THROTTLED(CAP_THROTTLED)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_op_vld(in_op_vld), .in_kind(in_kind), .fl_count(fl_count), .fl_pop(fl_pop),
  .out_valid(out_valid), .out_op_vld(out_op_vld), .out_psrc_a(out_psrc_a),
  .out_pdst(out_pdst), .out_elim(out_elim), .out_rel_vld(out_rel_vld),
  .out_rel_preg(out_rel_preg)
);

// File: tb/sim_rn_rename.sv
`timescale 1ns/1ps
module sim_rn_rename;
  localparam int L = 2;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid, in_ready;
  logic [L-1:0]     in_op_vld, in_wr;
  logic [L-1:0][1:0] in_kind;
  logic [L-1:0][3:0] in_src_a, in_src_b, in_dst;
  logic [1:0]       fl_count, fl_pop;
  logic [L-1:0][5:0] fl_preg;
  logic             out_valid;
  logic [L-1:0]     out_op_vld, out_elim, out_rel_vld;
  logic [L-1:0][5:0] out_psrc_a, out_psrc_b, out_pdst, out_rel_preg;

  always #4 clk = ~clk;

  rn_rename u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op_vld(in_op_vld), .in_kind(in_kind), .in_wr(in_wr),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .fl_count(fl_count), .fl_preg(fl_preg), .fl_pop(fl_pop),
    .out_valid(out_valid), .out_op_vld(out_op_vld), .out_psrc_a(out_psrc_a),
    .out_psrc_b(out_psrc_b), .out_pdst(out_pdst), .out_elim(out_elim),
    .out_rel_vld(out_rel_vld), .out_rel_preg(out_rel_preg)
  );

  int nchk = 0, nerr = 0;
  int freeq[$];
  int lim = -1;
  int cand[L];
  // reference state: one name count per physical register
  int mmap[16], refc[64], prev_el;
  int wm[16], wrc[64], e_nal, e_nmv;
  int e_ready, e_fire;
  int e_ov[L], e_pa[L], e_pb[L], e_pd[L], e_el[L], e_rv[L], e_rp[L];

  task automatic chk(input int got, input int exp, input string what);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", what, got, exp);
    end
  endtask

  function automatic int slots_used();
    int n = 0;
    for (int p = 1; p < 64; p++) if (wrc[p] >= 2) n++;
    return n;
  endfunction

  function automatic void model_eval();
    int cap, pa, np, old;
    bit wrt;
    wm = mmap; wrc = refc; e_nal = 0; e_nmv = 0;
    cap = (prev_el >= 2) ? 1 : 2;
    for (int l = 0; l < L; l++) begin
      e_ov[l] = in_op_vld[l]; e_pa[l] = 0; e_pb[l] = 0; e_pd[l] = 0;
      e_el[l] = 0; e_rv[l] = 0; e_rp[l] = 0;
      if (!in_op_vld[l]) continue;
      pa = wm[in_src_a[l]];
      e_pa[l] = pa; e_pb[l] = wm[in_src_b[l]];
      wrt = 0; np = 0;
      if (in_kind[l] == 2'd1) begin
        wrt = 1;
        if (e_nmv < cap && (pa == 0 || wrc[pa] >= 2 || slots_used() < 4)) begin
          e_el[l] = 1; e_nmv++; np = pa;
          if (pa != 0) wrc[pa]++;
        end else begin
          np = cand[e_nal]; e_nal++; wrc[np] = 1;
        end
      end else if (in_kind[l] == 2'd2) begin
        wrt = 1; e_el[l] = 1; e_pa[l] = 0; e_pb[l] = 0; np = 0;
      end else if (in_wr[l]) begin
        wrt = 1; np = cand[e_nal]; e_nal++; wrc[np] = 1;
      end
      if (wrt) begin
        old = wm[in_dst[l]];
        if (old != 0) begin
          wrc[old]--;
          if (wrc[old] == 0) begin e_rv[l] = 1; e_rp[l] = old; end
        end
        wm[in_dst[l]] = np;
        e_pd[l] = np;
      end
    end
    e_ready = (e_nal <= int'(fl_count));
    e_fire  = in_valid && e_ready;
  endfunction

  task automatic drive_free();
    int n;
    n = (freeq.size() < L) ? freeq.size() : L;
    if (lim >= 0 && lim < n) n = lim;
    fl_count = 2'(n);
    for (int k = 0; k < L; k++) begin
      cand[k] = (k < freeq.size()) ? freeq[k] : 0;
      fl_preg[k] = 6'(cand[k]);
    end
  endtask

  task automatic step();
    drive_free();
    #1;
    model_eval();
    chk(in_ready, e_ready, "R9 in_ready");
    chk(fl_pop, e_fire ? e_nal : 0, "R9 fl_pop");
    @(posedge clk);
    prev_el = e_fire ? e_nmv : 0;
    if (e_fire) begin
      mmap = wm; refc = wrc;
      for (int k = 0; k < e_nal; k++) void'(freeq.pop_front());
      for (int l = 0; l < L; l++) if (e_rv[l]) freeq.push_back(e_rp[l]);
    end
    @(negedge clk);
    chk(out_valid, e_fire, "R10 out_valid");
    if (e_fire) begin
      for (int l = 0; l < L; l++) begin
        chk(out_op_vld[l], e_ov[l], "R10 out_op_vld");
        chk(out_psrc_a[l], e_pa[l], "R8 out_psrc_a");
        chk(out_psrc_b[l], e_pb[l], "R8 out_psrc_b");
        chk(out_pdst[l], e_pd[l], "R2 out_pdst");
        chk(out_elim[l], e_el[l], "R4 out_elim");
        chk(out_rel_vld[l], e_rv[l], "R11 out_rel_vld");
        chk(out_rel_preg[l], e_rp[l], "R11 out_rel_preg");
      end
    end
  endtask

  task automatic set_op(input int l, input bit v, input int k, input bit w,
                        input int a, input int b, input int d);
    in_op_vld[l] = v; in_kind[l] = 2'(k); in_wr[l] = w;
    in_src_a[l] = 4'(a); in_src_b[l] = 4'(b); in_dst[l] = 4'(d);
  endtask

  task automatic one(input int k, input bit w, input int a, input int d);
    in_valid = 1'b1;
    set_op(0, 1, k, w, a, 0, d);
    set_op(1, 0, 0, 0, 0, 0, 0);
    step();
  endtask

  initial begin
    #(8 * 100000);
    nerr++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0;
    for (int l = 0; l < L; l++) set_op(l, 0, 0, 0, 0, 0, 0);
    for (int p = 1; p < 64; p++) freeq.push_back(p);
    for (int a = 0; a < 16; a++) mmap[a] = 0;
    for (int p = 0; p < 64; p++) refc[p] = 0;
    prev_el = 0;
    drive_free();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    chk(out_valid, 0, "R1 out_valid after reset");
    chk(in_ready, 1, "R1 ready with empty bundle");

    // R1/R2: first write reads zero register, takes first candidate
    one(0, 1, 3, 1);
    chk(out_psrc_a[0], 0, "R1 reset mapping is zero register");
    chk(out_pdst[0], 1, "R2 first candidate taken");
    in_valid = 1;
    set_op(0, 1, 0, 1, 1, 0, 2); set_op(1, 1, 0, 1, 2, 0, 3); step();
    set_op(0, 1, 0, 1, 1, 0, 4); set_op(1, 1, 0, 1, 2, 0, 5); step();
    chk(out_pdst[1], 5, "R2 lane order of candidates");

    // R3: copy completed at rename
    one(1, 0, 1, 8);
    chk(out_elim[0], 1, "R3 copy completed at rename");
    chk(out_pdst[0], 1, "R3 destination aliases source");
    one(1, 0, 2, 9);
    one(1, 0, 3, 10);
    one(1, 0, 4, 11);
    // R5: four slots busy, next copy falls back
    one(1, 0, 5, 12);
    chk(out_elim[0], 0, "R5 fallback when no slot free");
    chk(out_psrc_a[0], 5, "R5 fallback copy reads source");
    chk(out_pdst[0], 6, "R5 fallback takes fresh register");
    // R6: overwrite ends sharing, slot reusable, no release
    one(0, 1, 0, 8);
    chk(out_rel_vld[0], 0, "R6 still-named register not released");
    one(1, 0, 5, 13);
    chk(out_elim[0], 1, "R6 freed slot reused");
    // R7: zeroing idiom and copy of zero
    one(2, 0, 3, 9);
    chk(out_elim[0], 1, "R7 zeroing completed");
    chk(out_pdst[0], 0, "R7 zeroing maps to register 0");
    one(1, 0, 9, 14);
    chk(out_elim[0], 1, "R7 copy of zero completed");
    chk(out_pdst[0], 0, "R7 copy of zero maps to register 0");
    // R8: lane 1 sees lane 0 write and alias
    in_valid = 1;
    set_op(0, 1, 0, 1, 1, 0, 6); set_op(1, 1, 1, 0, 6, 0, 7); step();
    chk(out_psrc_a[1], out_pdst[0], "R8 lane 1 reads lane 0 result");
    chk(out_elim[1], 1, "R8 copy of same-bundle result completed");
    chk(out_pdst[1], out_pdst[0], "R8 shared mapping inside bundle");
    // R4: two copies, then throttled to one
    set_op(0, 1, 1, 0, 0, 0, 10); set_op(1, 1, 1, 0, 0, 0, 11); step();
    chk(out_elim[0] + out_elim[1], 2, "R4 two copies at full cap");
    set_op(0, 1, 1, 0, 0, 0, 12); set_op(1, 1, 1, 0, 0, 0, 13); step();
    chk(out_elim[0], 1, "R4 first copy under throttled cap");
    chk(out_elim[1], 0, "R4 second copy falls back under throttled cap");
    // R9: stall without enough candidates
    lim = 0;
    set_op(0, 1, 0, 1, 1, 0, 15); set_op(1, 0, 0, 0, 0, 0, 0); step();
    chk(in_ready, 0, "R9 stall with no candidates");
    chk(out_valid, 0, "R9 stalled bundle not issued");
    lim = 1;
    set_op(0, 1, 0, 1, 1, 0, 15); set_op(1, 1, 0, 1, 1, 0, 14); step();
    chk(in_ready, 0, "R9 whole bundle stalls on one short");
    lim = -1;
    step();
    chk(out_valid, 1, "R10 bundle issued once candidates return");

    // randomised traffic
    for (int c = 0; c < 3000; c++) begin
      int span;
      span = (c % 3 == 0) ? 16 : 6;
      in_valid = ($urandom % 8) != 0;
      for (int l = 0; l < L; l++) begin
        int r;
        r = $urandom % 10;
        set_op(l, ($urandom % 10) != 0, (r < 4) ? 1 : ((r < 5) ? 2 : 0), r != 9,
               $urandom % span, $urandom % span, $urandom % span);
      end
      lim = (($urandom % 8) == 0) ? int'($urandom % 3) : -1;
      step();
    end

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule